// File: doc/BRIEF.md
# SPI Frame Sequencer with Discarded-Response Prefix

This block runs one serial peripheral frame per command. A 32-bit command word names the peripheral to select, the frame length in bytes, how many leading bytes have their received data dropped, whether the frame is transmit-only, and whether the read phase after the dropped prefix uses two data lines. The engine pulls outgoing bytes from a show-ahead transmit FIFO, shifts them one bit per bit tick, pushes the received bytes it keeps into a receive FIFO, and pulses a done flag when the last byte has shifted.

The typical use is a flash-style access. A command and address are sent while the peripheral's replies are thrown away, then data is read back, optionally two bits per tick. Bit timing comes from an external `bit_tick_i` strobe, so no divider sits inside. Character length and the reverse-order bit together choose the bit order on the wire. A loopback input feeds the transmit line back into the receiver.

Top module: `spi_xfer_engine`

## Requirements
- R1: A `cmd_valid_i` pulse while idle starts a frame and drives exactly one chip select low, the one indexed by command bits [31:30] (value k lowers `cs_n_o[k]`). A `cmd_valid_i` pulse while a frame is running is ignored.
- R2: A frame moves (bits [15:0] + 1) bytes. `done_o` is high for one cycle, the cycle after the final bit tick of the last byte. All chip selects are high in the following cycle.
- R3: The received data of the first N bytes is not pushed, where N is command bits [23:16]. Only the bytes from index N onward are pushed, and none when N reaches the frame length.
- R4: With command bit 27 set, no byte is pushed to the receive FIFO during the whole frame.
- R5: With command bit 28 set and a non-zero skip count, each byte after the skip prefix takes 4 ticks. Each tick captures the pair {`miso_i[1]`, `miso_i[0]`}, with line 1 the more significant bit of the pair. `mosi_o` stays low in that phase and no transmit byte is popped for it.
- R6: Command bit 28 has no effect when the skip count is zero. The frame then runs on a single line, with 8 ticks per byte and `miso_i[0]` as input.
- R7: Bytes shift MSB-first when `rev_order_i` is 1 and `char_len_i` (bits minus one) is 7 or 15. In every other case they shift LSB-first. The receiver assembles bits in the same order.
- R8: With `loop_i` set, receive line 0 takes `mosi_o` instead of `miso_i[0]`.
- R9: When a single-line byte is due and `tx_empty_i` is high, the engine waits with chip select held and gives no clock pulses and no pops until data is available.
- R10: `sclk_o` is high for exactly the cycles in which a bit tick advances a bit. `mosi_o` is stable during that cycle, and `sclk_o` never pulses with all chip selects high.
- R11: While reset is held, all chip selects are high and `sclk_o`, `done_o`, `rx_push_o` and `tx_pop_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Start strobe for `cmd_i` |
| cmd_i | input | 32 | Command word |
| char_len_i | input | 4 | Character length minus one, static during a frame |
| rev_order_i | input | 1 | Request MSB-first order |
| loop_i | input | 1 | Internal loopback of the transmit line |
| bit_tick_i | input | 1 | One strobe per bit period |
| tx_data_i | input | 8 | Head of the transmit FIFO |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_pop_o | output | 1 | Consume the transmit FIFO head |
| rx_data_o | output | 8 | Received byte |
| rx_push_o | output | 1 | Write `rx_data_o` to the receive FIFO |
| sclk_o | output | 1 | Serial clock pulse |
| cs_n_o | output | 4 | Chip selects, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 2 | Serial data in, lines 1 and 0 |
| done_o | output | 1 | End-of-frame pulse |

## Verification
A pop is combinational and falls in the cycle where a byte is being loaded. `sclk_o` is high in the same cycle as the tick it answers. A push appears one cycle after the byte's final tick, which is also the cycle `done_o` rises for the last byte, and chip selects release one cycle later. The bench drives inputs one time unit after the rising edge and samples every output at the falling edge, so each event is counted in the cycle it is due. It compares per-frame totals of pops, pushes, pulses and done pulses, the first pushed byte and the first eight serial bits against a table of vectors. Directed cases cover reset, a command during a frame and a stalled transmit FIFO.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int CS_W     = 2;
  localparam int NUM_CS   = 1 << CS_W;
  localparam int LEN_W    = 16;
  localparam int SKIP_W   = 8;
  localparam int BYTE_W   = 8;
  localparam int CLEN_W   = 4;
  localparam int CMD_W    = 32;
  // command word field positions
  localparam int CS_LSB   = 30;
  localparam int DUAL_BIT = 28;
  localparam int TXO_BIT  = 27;
  localparam int SKIP_LSB = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_DONE} xfer_state_e;

  typedef struct packed {
    logic [CS_W-1:0]   cs;
    logic              dual;
    logic              tx_only;
    logic [SKIP_W-1:0] skip;
    logic [LEN_W-1:0]  len_m1;
  } xfer_cmd_t;
endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_xfer_pkg::*;
(
  input  logic [CMD_W-1:0]  cmd_word_i,
  input  logic [CLEN_W-1:0] char_len_i,
  input  logic              rev_order_i,
  output xfer_cmd_t         cmd_o,
  output logic              msb_first_o
);
  logic unused_bits;
  assign unused_bits = ^{cmd_word_i[29], cmd_word_i[26:SKIP_LSB+SKIP_W]};

  assign cmd_o.cs      = cmd_word_i[CS_LSB +: CS_W];
  assign cmd_o.dual    = cmd_word_i[DUAL_BIT];
  assign cmd_o.tx_only = cmd_word_i[TXO_BIT];
  assign cmd_o.skip    = cmd_word_i[SKIP_LSB +: SKIP_W];
  assign cmd_o.len_m1  = cmd_word_i[LEN_W-1:0];

  // MSB-first only for one- or two-byte characters
  assign msb_first_o = rev_order_i &&
                       (char_len_i == CLEN_W'(BYTE_W - 1) ||
                        char_len_i == CLEN_W'(2 * BYTE_W - 1));
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_xfer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_data_i,
  input  logic              step_i,
  input  logic              msb_first_i,
  input  logic              dual_i,
  input  logic [1:0]        rx_line_i,
  output logic              mosi_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_next_o
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;

  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [BYTE_W-1:0] tx_q, rx_q;

  assign cnt_nxt     = cnt_q + (dual_i ? CNT_W'(2) : CNT_W'(1));
  assign byte_done_o = step_i && (cnt_nxt >= CNT_W'(BYTE_W));
  assign mosi_o      = dual_i ? 1'b0 : (msb_first_i ? tx_q[BYTE_W-1] : tx_q[0]);

  always_comb begin
    unique case ({dual_i, msb_first_i})
      2'b00:   rx_next_o = {rx_line_i[0], rx_q[BYTE_W-1:1]};
      2'b01:   rx_next_o = {rx_q[BYTE_W-2:0], rx_line_i[0]};
      2'b10:   rx_next_o = {rx_line_i[1], rx_line_i[0], rx_q[BYTE_W-1:2]};
      default: rx_next_o = {rx_q[BYTE_W-3:0], rx_line_i[1], rx_line_i[0]};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      tx_q  <= load_data_i;
      rx_q  <= '0;
    end else if (step_i) begin
      tx_q  <= msb_first_i ? {tx_q[BYTE_W-2:0], 1'b0} : {1'b0, tx_q[BYTE_W-1:1]};
      rx_q  <= rx_next_o;
      cnt_q <= byte_done_o ? '0 : cnt_nxt;
    end
  end

  // R5 / R10: bit counter never reaches a full byte between steps
  p_cnt_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(BYTE_W));
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_xfer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  xfer_cmd_t         cmd_i,
  input  logic              tx_empty_i,
  input  logic              bit_tick_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              tx_pop_o,
  output logic              load_o,
  output logic              step_o,
  output logic              dual_ph_o,
  output logic              rx_push_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              done_o,
  output logic [NUM_CS-1:0] cs_n_o
);
  xfer_state_e       state_q;
  xfer_cmd_t         cmd_q;
  logic [LEN_W-1:0]  byte_idx_q;
  logic              skip_ph, owe_tx, last_byte, keep;

  assign skip_ph   = byte_idx_q < LEN_W'(cmd_q.skip);
  assign dual_ph_o = cmd_q.dual && (cmd_q.skip != '0) && !skip_ph;
  assign owe_tx    = !dual_ph_o;
  assign last_byte = byte_idx_q == cmd_q.len_m1;
  assign keep      = !cmd_q.tx_only && !skip_ph;

  assign tx_pop_o = (state_q == ST_LOAD) && owe_tx && !tx_empty_i;
  assign load_o   = (state_q == ST_LOAD) && (!owe_tx || !tx_empty_i);
  assign step_o   = (state_q == ST_SHIFT) && bit_tick_i;
  assign done_o   = (state_q == ST_DONE);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n_o[i] = !((state_q != ST_IDLE) && (cmd_q.cs == CS_W'(i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cmd_q      <= '0;
      byte_idx_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          cmd_q      <= cmd_i;
          byte_idx_q <= '0;
          state_q    <= ST_LOAD;
        end
        ST_LOAD: if (load_o) state_q <= ST_SHIFT;
        ST_SHIFT: if (step_o && byte_done_i) begin
          if (last_byte) state_q <= ST_DONE;
          else begin
            byte_idx_q <= byte_idx_q + 1'b1;
            state_q    <= ST_LOAD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_push_o <= 1'b0;
      rx_data_o <= '0;
    end else begin
      rx_push_o <= step_o && byte_done_i && keep;
      if (step_o && byte_done_i) rx_data_o <= rx_byte_i;
    end
  end

  p_txonly_no_push_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> !cmd_q.tx_only);
  p_skip_no_push_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> $past(!skip_ph));
  p_done_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && owe_tx && tx_empty_i) |=> state_q == ST_LOAD);
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [CLEN_W-1:0] char_len_i,
  input  logic              rev_order_i,
  input  logic              loop_i,
  input  logic              bit_tick_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_empty_i,
  output logic              tx_pop_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_push_o,
  output logic              sclk_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              mosi_o,
  input  logic [1:0]        miso_i,
  output logic              done_o
);
  xfer_cmd_t         dec_cmd;
  logic              msb_first, load, step, dual_ph, byte_done, mosi_int;
  logic [BYTE_W-1:0] rx_next, load_data;
  logic [1:0]        rx_line;

  assign rx_line   = {miso_i[1], loop_i ? mosi_int : miso_i[0]};
  assign load_data = dual_ph ? '0 : tx_data_i;
  assign sclk_o    = step;
  assign mosi_o    = mosi_int;

  spi_cmd_decode u_dec (
    .cmd_word_i (cmd_i),
    .char_len_i (char_len_i),
    .rev_order_i(rev_order_i),
    .cmd_o      (dec_cmd),
    .msb_first_o(msb_first)
  );

  spi_frame_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_i      (dec_cmd),
    .tx_empty_i (tx_empty_i),
    .bit_tick_i (bit_tick_i),
    .byte_done_i(byte_done),
    .rx_byte_i  (rx_next),
    .tx_pop_o   (tx_pop_o),
    .load_o     (load),
    .step_o     (step),
    .dual_ph_o  (dual_ph),
    .rx_push_o  (rx_push_o),
    .rx_data_o  (rx_data_o),
    .done_o     (done_o),
    .cs_n_o     (cs_n_o)
  );

  spi_byte_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_data_i(load_data),
    .step_i     (step),
    .msb_first_i(msb_first),
    .dual_i     (dual_ph),
    .rx_line_i  (rx_line),
    .mosi_o     (mosi_int),
    .byte_done_o(byte_done),
    .rx_next_o  (rx_next)
  );

  p_cs_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  p_cs_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (&cs_n_o));
  p_sclk_in_frame_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !(&cs_n_o));
endmodule

// File: tb/sim_spi_xfer_engine.sv
module sim_spi_xfer_engine;
  typedef struct packed {
    logic [1:0]  cs;
    logic        dual;
    logic        txo;
    logic [7:0]  skip;
    logic [15:0] len_m1;
    logic [3:0]  clen;
    logic        rev;
    logic        loop;
    logic [1:0]  miso;
    logic [7:0]  seed;
    logic [15:0] e_push;
    logic [7:0]  e_first;
    logic [15:0] e_pop;
    logic [7:0]  e_cap;
    logic [15:0] e_ticks;
  } vec_t;

  localparam int NV = 8;
  // cs dual txo skip len_m1 clen rev loop miso seed | push first pop cap ticks
  localparam vec_t VECS [NV] = '{
    '{2'd1,1'b0,1'b0,8'd0,16'd3,4'd7, 1'b1,1'b1,2'b00,8'h1D,16'd4,8'h1D,16'd4,8'h1D,16'd32}, // R2 R7 R8
    '{2'd2,1'b0,1'b0,8'd1,16'd2,4'd3, 1'b1,1'b1,2'b00,8'h1D,16'd2,8'h1E,16'd3,8'hB8,16'd24}, // R3 R7
    '{2'd0,1'b0,1'b1,8'd0,16'd4,4'd15,1'b1,1'b1,2'b00,8'h1D,16'd0,8'h00,16'd5,8'h1D,16'd40}, // R4 R7
    '{2'd1,1'b1,1'b0,8'd2,16'd4,4'd7, 1'b1,1'b0,2'b10,8'h1D,16'd3,8'hAA,16'd2,8'h1D,16'd28}, // R5
    '{2'd3,1'b1,1'b0,8'd0,16'd1,4'd7, 1'b0,1'b0,2'b01,8'h40,16'd2,8'hFF,16'd2,8'h02,16'd16}, // R6
    '{2'd2,1'b1,1'b0,8'd1,16'd2,4'd7, 1'b0,1'b0,2'b01,8'h80,16'd2,8'h55,16'd1,8'h01,16'd16}, // R5
    '{2'd0,1'b0,1'b0,8'd3,16'd1,4'd7, 1'b0,1'b1,2'b00,8'h1D,16'd0,8'h00,16'd2,8'hB8,16'd16}, // R3
    '{2'd3,1'b0,1'b0,8'd0,16'd0,4'd7, 1'b1,1'b1,2'b00,8'hF0,16'd1,8'hF0,16'd1,8'hF0,16'd8}   // R1 R10
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [31:0] cmd = '0;
  logic [3:0] clen = 4'd7;
  logic       rev = 1'b0, loop = 1'b0, tick = 1'b0, tx_empty = 1'b0;
  logic [1:0] miso = 2'b00;
  logic [7:0] seed = '0, tx_idx = '0;
  logic [7:0] tx_data, rx_data;
  logic       tx_pop, rx_push, sclk, mosi, done;
  logic [3:0] cs_n;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_pop = 0, n_push = 0, n_tick = 0, n_done = 0, cs_bad = 0, rel_bad = 0;
  int pop_b = 0, push_b = 0, tick_b = 0, done_b = 0, csb_b = 0, rel_b = 0;
  logic [7:0] cap = '0, first = '0;
  logic [3:0] exp_csn = 4'hF;
  logic       done_prev = 1'b0;
  bit         tick_en = 1'b1;

  always #4 clk = ~clk;

  assign tx_data = seed + tx_idx;

  spi_xfer_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .char_len_i(clen), .rev_order_i(rev), .loop_i(loop), .bit_tick_i(tick),
    .tx_data_i(tx_data), .tx_empty_i(tx_empty), .tx_pop_o(tx_pop),
    .rx_data_o(rx_data), .rx_push_o(rx_push), .sclk_o(sclk), .cs_n_o(cs_n),
    .mosi_o(mosi), .miso_i(miso), .done_o(done)
  );

  // monitor: sample mid-cycle
  always @(negedge clk) begin
    if (tx_pop) n_pop++;
    if (rx_push) begin
      if (n_push == push_b) first = rx_data;
      n_push++;
    end
    if (sclk) begin
      if (n_tick - tick_b < 8) cap = {cap[6:0], mosi};
      n_tick++;
      if (cs_n !== exp_csn) cs_bad++;
    end
    if (done_prev && cs_n !== 4'hF) rel_bad++;
    done_prev = done;
    if (done) n_done++;
  end

  // tick strobe every 4 cycles, transmit FIFO index follows pops
  initial begin
    int div = 0;
    forever begin
      @(posedge clk); #1;
      tx_idx = 8'(n_pop - pop_b);
      div++;
      tick = tick_en && (div % 4 == 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog: got %0d cycles expected < 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_base();
    pop_b = n_pop; push_b = n_push; tick_b = n_tick; done_b = n_done;
    csb_b = cs_bad; rel_b = rel_bad;
  endtask

  task automatic start(input vec_t v);
    @(posedge clk); #2;
    set_base();
    seed = v.seed; clen = v.clen; rev = v.rev; loop = v.loop; miso = v.miso;
    exp_csn = ~(4'b1 << v.cs);
    cmd = {v.cs, 1'b0, v.dual, v.txo, 3'b000, v.skip, v.len_m1};
    cmd_valid = 1'b1;
    @(posedge clk); #2;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && n_done == done_b; i++) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    vec_t d;
    // R11: reset state
    repeat (3) @(negedge clk);
    check(cs_n === 4'hF, "R11", "cs_n in reset", cs_n, 4'hF);
    check(sclk === 1'b0, "R11", "sclk in reset", sclk, 0);
    check({done, rx_push, tx_pop} === 3'b000, "R11", "done/push/pop in reset",
          {done, rx_push, tx_pop}, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int k = 0; k < NV; k++) begin
      start(VECS[k]);
      wait_done();
      check(n_done - done_b == 1, "R2", $sformatf("v%0d done count", k), n_done - done_b, 1);
      check(rel_bad == rel_b, "R2", $sformatf("v%0d cs release after done", k), rel_bad - rel_b, 0);
      check(n_tick - tick_b == int'(VECS[k].e_ticks), "R5", $sformatf("v%0d sclk pulses", k),
            n_tick - tick_b, VECS[k].e_ticks);
      check(n_pop - pop_b == int'(VECS[k].e_pop), "R5", $sformatf("v%0d tx pops", k),
            n_pop - pop_b, VECS[k].e_pop);
      check(n_push - push_b == int'(VECS[k].e_push), "R3", $sformatf("v%0d rx pushes", k),
            n_push - push_b, VECS[k].e_push);
      if (VECS[k].e_push != 0)
        check(first == VECS[k].e_first, "R8", $sformatf("v%0d first rx byte", k),
              first, VECS[k].e_first);
      check(cap == VECS[k].e_cap, "R7", $sformatf("v%0d first mosi bits", k),
            cap, VECS[k].e_cap);
      check(cs_bad == csb_b, "R1", $sformatf("v%0d cs during pulses", k), cs_bad - csb_b, 0);
    end

    // R1: command during a frame is ignored
    d = VECS[7];
    d.cs = 2'd0; d.len_m1 = 16'd2; d.e_ticks = 16'd24;
    start(d);
    repeat (5) @(posedge clk); #2;
    cmd = {2'd2, 30'd0};
    cmd_valid = 1'b1;
    @(posedge clk); #2; cmd_valid = 1'b0;
    wait_done();
    check(n_tick - tick_b == 24, "R1", "pulses with busy command", n_tick - tick_b, 24);
    check(n_done - done_b == 1, "R1", "done count with busy command", n_done - done_b, 1);
    check(cs_bad == csb_b, "R1", "cs held to first command", cs_bad - csb_b, 0);
    set_base();
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(n_tick == tick_b, "R1", "no second frame pulses", n_tick - tick_b, 0);
    check(cs_n === 4'hF, "R1", "idle cs after ignored command", cs_n, 4'hF);

    // R9: empty transmit FIFO stalls the frame
    d = VECS[0];
    d.len_m1 = 16'd1;
    tx_empty = 1'b1;
    start(d);
    repeat (60) @(posedge clk);
    @(negedge clk);
    check(n_tick == tick_b, "R9", "pulses while empty", n_tick - tick_b, 0);
    check(n_pop == pop_b, "R9", "pops while empty", n_pop - pop_b, 0);
    check(cs_n === 4'b1101, "R9", "cs held while empty", cs_n, 4'b1101);
    @(posedge clk); #2; tx_empty = 1'b0;
    wait_done();
    check(n_tick - tick_b == 16, "R9", "pulses after refill", n_tick - tick_b, 16);
    check(n_pop - pop_b == 2, "R9", "pops after refill", n_pop - pop_b, 2);
    check(first == 8'h1D, "R10", "loop byte after stall", first, 8'h1D);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule